// File: doc/BRIEF.md
# Paged GPIO Controller with Edge Interrupts

This block serves 48 general-purpose lines, grouped as six byte-wide ports, behind a small synchronous register bus with an 8-bit address and 8-bit data. Each port has a data register. Writing a 1 to a bit enables the output driver of that line. Writing a 0 releases the line so that it can be used as an input. A read of the same address returns the synchronized level of the eight pads.

The three lowest ports can also raise interrupts. Their per-line settings sit in three banks: edge polarity, interrupt enable and pending status. Only one bank is visible at a time, through a three-address window. A two-bit field in a shared page register chooses which bank that window shows.

Every pad passes through a two-flop synchronizer before edge detection. An enabled line that sees an edge of its selected direction sets a sticky pending bit. The interrupt request stays high while any pending bit is set. Software clears pending bits by writing ones into the pending bank.

Top module: `pgpio_ctrl`

## Requirements
- R1: After reset, every output enable is 0 and the interrupt request is 0. Every register offset from 0 to 10 reads 0x00 while the pads are low.
- R2: A write to offset p (0 to 5) sets the output enables of lines 8p to 8p+7 to the written byte. Bit i of the byte controls line 8p+i, and a 1 enables the driver.
- R3: A read strobe at a clock edge loads the read data that appears after that edge. The read data holds its value while no read strobe is given. A read of offset p (0 to 5) returns the levels of lines 8p to 8p+7 as they were two clock edges earlier.
- R4: Offset 7 is a full 8-bit page register that reads back what was written. Its bits 7:6 choose the bank shown at offsets 8, 9 and 10, which map to ports 0, 1 and 2: 1 shows polarity, 2 shows enable and 3 shows pending. With the field at 0, those offsets read 0x00 and ignore writes.
- R5: A polarity bit of 1 captures rising edges and 0 captures falling edges. Edges of the other direction are not captured. A pad change set up before clock edge k first shows as a pending bit and as an interrupt request after edge k+2.
- R6: A line whose enable bit is 0 captures no edge. Writing 0x00 to all three enable registers prevents every new pending bit.
- R7: In the pending bank, a written 1 clears that pending bit and a written 0 leaves it unchanged. An edge captured in the same cycle as the clear keeps the bit set.
- R8: The interrupt request is high exactly while at least one pending bit is set. It stays high until the pending bits are cleared.
- R9: Lines 24 to 47 never produce a pending bit or an interrupt request.
- R10: Offset 6 and offsets 11 and above read 0x00, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, loads bus_rdata |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 48 | Pad input levels, asynchronous |
| pad_oe | output | 48 | Pad output enables, 1 drives the line |
| irq_out | output | 1 | Interrupt request |

## Verification
Four properties are checked on every cycle:
- The port-0 enables follow a data write one cycle later.
- The read data stays stable when no read strobe is given.
- Offset 6, and the bank window with a zero page field, read as zero.
- A raised interrupt request stays high until a pending-bank write, and no pending bit appears while every enable is clear.

Only the bench scenarios can show the rest: the exact two-edge latency from a pad change to a pending bit, the rejection of edges in the wrong direction, and the rule that a capture beats a clear in the same cycle. The same holds for the silence of the upper 24 lines and for the level-versus-register split of the data offsets. A behavioural model is compared on every clock across directed and pseudo-random traffic.

// File: rtl/pgpio_pkg.sv
package pgpio_pkg;

    // Bank selection carried in the top two bits of the page register
    typedef enum logic [1:0] {
        PG_NONE = 2'd0,
        PG_POL  = 2'd1,
        PG_EN   = 2'd2,
        PG_PEND = 2'd3
    } page_e;

endpackage

// File: rtl/pgpio_sync.sv
module pgpio_sync #(
    parameter int W      = 48,
    parameter int EDGE_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      level,
    output logic [EDGE_W-1:0] rise,
    output logic [EDGE_W-1:0] fall
);

    typedef struct packed {
        logic [W-1:0]      s1;
        logic [W-1:0]      s2;
        logic [EDGE_W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pad_in;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2[EDGE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.s2;
    assign rise  = st_q.s2[EDGE_W-1:0] & ~st_q.prev;
    assign fall  = ~st_q.s2[EDGE_W-1:0] & st_q.prev;

endmodule

// File: rtl/pgpio_irq_port.sv
module pgpio_irq_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rise,
    input  logic [W-1:0] fall,
    input  logic [W-1:0] wdata,
    input  logic         pol_we,
    input  logic         en_we,
    input  logic         ack_we,
    output logic [W-1:0] pol_q,
    output logic [W-1:0] en_q,
    output logic [W-1:0] pend_q
);

    typedef struct packed {
        logic [W-1:0] pol;
        logic [W-1:0] en;
        logic [W-1:0] pend;
    } bank_t;

    bank_t b_d, b_q;
    logic [W-1:0] cap_d;
    logic [W-1:0] clr_d;

    always_comb begin
        b_d   = b_q;
        cap_d = b_q.en & ((b_q.pol & rise) | (~b_q.pol & fall));
        clr_d = ack_we ? wdata : '0;
        if (pol_we) b_d.pol = wdata;
        if (en_we)  b_d.en  = wdata;
        // a capture in the same cycle wins over the clear
        b_d.pend = (b_q.pend & ~clr_d) | cap_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign pol_q  = b_q.pol;
    assign en_q   = b_q.en;
    assign pend_q = b_q.pend;

endmodule

// File: rtl/pgpio_ctrl.sv
module pgpio_ctrl #(
    parameter int NUM_PORTS = 6,
    parameter int IRQ_PORTS = 3,
    parameter int PORT_W    = 8,
    parameter int AW        = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [AW-1:0]               bus_addr,
    input  logic [PORT_W-1:0]           bus_wdata,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    output logic [PORT_W-1:0]           bus_rdata,
    input  logic [NUM_PORTS*PORT_W-1:0] pad_in,
    output logic [NUM_PORTS*PORT_W-1:0] pad_oe,
    output logic                        irq_out
);
    import pgpio_pkg::*;

    localparam int NUM_LINES = NUM_PORTS * PORT_W;
    localparam int IRQ_LINES = IRQ_PORTS * PORT_W;
    localparam int PAGE_OFS  = NUM_PORTS + 1;
    localparam int BANK_OFS  = NUM_PORTS + 2;

    typedef struct packed {
        logic [NUM_LINES-1:0] oe;
        logic [PORT_W-1:0]    page;
        logic [PORT_W-1:0]    rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [NUM_LINES-1:0] level;
    logic [IRQ_LINES-1:0] rise, fall;
    logic [IRQ_LINES-1:0] pol_all, en_all, pend_all;
    logic [PORT_W-1:0]    page_q;
    logic [PORT_W-1:0]    rd_mux;
    page_e                page_sel;

    assign page_q   = r_q.page;
    assign page_sel = page_e'(page_q[PORT_W-1 -: 2]);

    pgpio_sync #(.W(NUM_LINES), .EDGE_W(IRQ_LINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .level  (level),
        .rise   (rise),
        .fall   (fall)
    );

    for (genvar p = 0; p < IRQ_PORTS; p++) begin : g_irq
        logic hit;
        assign hit = bus_wr && (bus_addr == AW'(BANK_OFS + p));

        pgpio_irq_port #(.W(PORT_W)) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .rise   (rise[p*PORT_W +: PORT_W]),
            .fall   (fall[p*PORT_W +: PORT_W]),
            .wdata  (bus_wdata),
            .pol_we (hit && (page_sel == PG_POL)),
            .en_we  (hit && (page_sel == PG_EN)),
            .ack_we (hit && (page_sel == PG_PEND)),
            .pol_q  (pol_all[p*PORT_W +: PORT_W]),
            .en_q   (en_all[p*PORT_W +: PORT_W]),
            .pend_q (pend_all[p*PORT_W +: PORT_W])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (bus_addr == AW'(p)) rd_mux = level[p*PORT_W +: PORT_W];
        end
        if (bus_addr == AW'(PAGE_OFS)) rd_mux = page_q;
        for (int p = 0; p < IRQ_PORTS; p++) begin
            if (bus_addr == AW'(BANK_OFS + p)) begin
                case (page_sel)
                    PG_POL:  rd_mux = pol_all[p*PORT_W +: PORT_W];
                    PG_EN:   rd_mux = en_all[p*PORT_W +: PORT_W];
                    PG_PEND: rd_mux = pend_all[p*PORT_W +: PORT_W];
                    default: rd_mux = '0;
                endcase
            end
        end
    end

    always_comb begin
        r_d = r_q;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (bus_wr && (bus_addr == AW'(p))) r_d.oe[p*PORT_W +: PORT_W] = bus_wdata;
        end
        if (bus_wr && (bus_addr == AW'(PAGE_OFS))) r_d.page = bus_wdata;
        if (bus_rd) r_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pad_oe    = r_q.oe;
    assign bus_rdata = r_q.rdata;
    assign irq_out   = |pend_all;

endmodule

// File: rtl/pgpio_ctrl_chk.sv
module pgpio_ctrl_chk #(
    parameter int NUM_PORTS = 6,
    parameter int IRQ_PORTS = 3,
    parameter int PORT_W    = 8,
    parameter int AW        = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [AW-1:0]               bus_addr,
    input logic [PORT_W-1:0]           bus_wdata,
    input logic                        bus_wr,
    input logic                        bus_rd,
    input logic [PORT_W-1:0]           bus_rdata,
    input logic [NUM_PORTS*PORT_W-1:0] pad_oe,
    input logic                        irq_out,
    input logic [PORT_W-1:0]           page_q,
    input logic [IRQ_PORTS*PORT_W-1:0] en_all,
    input logic [IRQ_PORTS*PORT_W-1:0] pend_all
);

    localparam int BANK_LO = NUM_PORTS + 2;
    localparam int BANK_HI = NUM_PORTS + 2 + IRQ_PORTS;

    logic in_bank;
    assign in_bank = (bus_addr >= AW'(BANK_LO)) && (bus_addr < AW'(BANK_HI));

    AST_OE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == '0) |=> pad_oe[PORT_W-1:0] == $past(bus_wdata)); // R2

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R3

    AST_PAGE0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && in_bank && page_q[PORT_W-1 -: 2] == 2'd0) |=> bus_rdata == '0); // R4

    AST_MASKED_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_all == '0 && pend_all == '0) |=> pend_all == '0); // R6

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !(bus_wr && in_bank && page_q[PORT_W-1 -: 2] == 2'd3)) |=> irq_out); // R8

    AST_RSV_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == AW'(NUM_PORTS)) |=> bus_rdata == '0); // R10

endmodule

bind pgpio_ctrl pgpio_ctrl_chk #(
    .NUM_PORTS (NUM_PORTS),
    .IRQ_PORTS (IRQ_PORTS),
    .PORT_W    (PORT_W),
    .AW        (AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .irq_out   (irq_out),
    .page_q    (page_q),
    .en_all    (en_all),
    .pend_all  (pend_all)
);

// File: tb/test_pgpio_ctrl.sv
module test_pgpio_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [47:0] pad_in = '0;
    logic [47:0] pad_oe;
    logic        irq_out;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgpio_ctrl i_pgpio_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .irq_out(irq_out)
    );

    // ---------------- behavioural reference model ----------------
    logic [47:0] m_oe, m_s1, m_s2;
    logic [23:0] m_prev, m_pol, m_en, m_pend, cap, clr;
    logic [7:0]  m_page, m_rdata;

    function automatic logic [7:0] m_read(input logic [7:0] a);
        int k;
        if (a <= 8'd5) return m_s2[a*8 +: 8];
        if (a == 8'd7) return m_page;
        if (a >= 8'd8 && a <= 8'd10) begin
            k = a - 8;
            case (m_page[7:6])
                2'd1: return m_pol[k*8 +: 8];
                2'd2: return m_en[k*8 +: 8];
                2'd3: return m_pend[k*8 +: 8];
                default: return 8'h00;
            endcase
        end
        return 8'h00;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_oe = '0; m_s1 = '0; m_s2 = '0; m_prev = '0;
            m_pol = '0; m_en = '0; m_pend = '0; m_page = '0; m_rdata = '0;
        end else begin
            if (bus_rd) m_rdata = m_read(bus_addr);
            cap = '0;
            clr = '0;
            for (int i = 0; i < 24; i++) begin
                if (m_en[i] && m_pol[i] && m_s2[i] && !m_prev[i]) cap[i] = 1'b1;
                if (m_en[i] && !m_pol[i] && !m_s2[i] && m_prev[i]) cap[i] = 1'b1;
            end
            if (bus_wr) begin
                if (bus_addr <= 8'd5) m_oe[bus_addr*8 +: 8] = bus_wdata;
                if (bus_addr == 8'd7) m_page = bus_wdata;
                if (bus_addr >= 8'd8 && bus_addr <= 8'd10) begin
                    case (m_page[7:6])
                        2'd1: m_pol[(bus_addr-8)*8 +: 8] = bus_wdata;
                        2'd2: m_en[(bus_addr-8)*8 +: 8] = bus_wdata;
                        2'd3: clr[(bus_addr-8)*8 +: 8] = bus_wdata;
                        default: ;
                    endcase
                end
            end
            m_pend = (m_pend & ~clr) | cap;
            m_prev = m_s2[23:0];
            m_s2 = m_s1;
            m_s1 = pad_in;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks += 3;
            if (pad_oe !== m_oe) begin
                fails++; $display("FAIL R2 model pad_oe actual %h expected %h", pad_oe, m_oe);
            end
            if (irq_out !== (|m_pend)) begin
                fails++; $display("FAIL R8 model irq_out actual %b expected %b", irq_out, |m_pend);
            end
            if (bus_rdata !== m_rdata) begin
                fails++; $display("FAIL R3 model rdata actual %h expected %h", bus_rdata, m_rdata);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input logic [47:0] got, input logic [47:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk); #1;
    endtask

    task automatic idle(input int n);
        repeat (n) cyc();
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cyc();
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        cyc();
        bus_rd = 1'b1; bus_addr = a;
        cyc();
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] v;
        rd(a, v);
        chk({40'd0, v}, {40'd0, exp}, tag);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] lf;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        chk(pad_oe, '0, "R1 pad_oe after reset");
        chk({47'd0, irq_out}, '0, "R1 irq after reset");
        for (int a = 0; a <= 10; a++) rd_chk(8'(a), 8'h00, "R1 reset read");

        // R2 data write drives enables
        wr(8'd0, 8'h5A);
        chk({40'd0, pad_oe[7:0]}, 48'h5A, "R2 port0 enables");
        wr(8'd5, 8'hC3);
        chk({40'd0, pad_oe[47:40]}, 48'hC3, "R2 port5 enables");

        // R3 data read returns pad level, not register
        pad_in[23:16] = 8'h96;
        idle(3);
        rd_chk(8'd2, 8'h96, "R3 port2 level");
        rd_chk(8'd0, 8'h00, "R3 port0 level not register");
        pad_in[23:16] = 8'h00;
        idle(3);

        // R4 bank selection
        wr(8'd7, 8'h80); wr(8'd8, 8'h11);
        wr(8'd7, 8'h40); wr(8'd8, 8'h01);
        rd_chk(8'd8, 8'h01, "R4 polarity bank");
        wr(8'd7, 8'h80);
        rd_chk(8'd8, 8'h11, "R4 enable bank");
        wr(8'd7, 8'h00);
        rd_chk(8'd8, 8'h00, "R4 page0 reads zero");
        wr(8'd8, 8'hFF);
        wr(8'd7, 8'h80);
        rd_chk(8'd8, 8'h11, "R4 page0 write ignored");
        rd_chk(8'd7, 8'h80, "R4 page readback");

        // R5 rising edge latency on line 0
        pad_in[0] = 1'b1;
        cyc(); cyc();
        chk({47'd0, irq_out}, '0, "R5 no irq after k+1");
        cyc();
        chk({47'd0, irq_out}, 48'd1, "R5 irq after k+2");
        wr(8'd7, 8'hC0);
        rd_chk(8'd8, 8'h01, "R5 pending line0");

        // R7 write-0 keeps, write-1 clears
        wr(8'd8, 8'h00);
        rd_chk(8'd8, 8'h01, "R7 zero leaves bit");
        wr(8'd8, 8'h01);
        rd_chk(8'd8, 8'h00, "R7 one clears bit");
        chk({47'd0, irq_out}, '0, "R8 irq drops after clear");

        // R5 falling polarity on line 4
        pad_in[4] = 1'b1; idle(4);
        rd_chk(8'd8, 8'h00, "R5 rising ignored on falling line");
        pad_in[4] = 1'b0; idle(4);
        rd_chk(8'd8, 8'h10, "R5 falling captured");
        chk({47'd0, irq_out}, 48'd1, "R8 irq held");
        idle(5);
        chk({47'd0, irq_out}, 48'd1, "R8 irq still held");
        wr(8'd8, 8'h10);

        // R6 masked line 1
        pad_in[1] = 1'b1; idle(4);
        pad_in[1] = 1'b0; idle(4);
        rd_chk(8'd8, 8'h00, "R6 masked line no pending");

        // R7 capture and clear in the same cycle
        pad_in[0] = 1'b0; idle(4);
        pad_in[0] = 1'b1;
        idle(1);
        wr(8'd8, 8'h01);
        rd_chk(8'd8, 8'h01, "R7 edge beats clear");
        wr(8'd8, 8'h01);
        rd_chk(8'd8, 8'h00, "R7 clear after race");

        // R6 disable everything
        wr(8'd7, 8'h80);
        wr(8'd8, 8'h00); wr(8'd9, 8'h00); wr(8'd10, 8'h00);
        pad_in[23:0] = 24'hFFFFFF; idle(4);
        pad_in[23:0] = 24'h000000; idle(4);
        chk({47'd0, irq_out}, '0, "R6 all disabled");

        // R9 upper lines silent even with lower enables set
        wr(8'd8, 8'hFF); wr(8'd9, 8'hFF); wr(8'd10, 8'hFF);
        pad_in[47:24] = 24'hFFFFFF; idle(4);
        pad_in[47:24] = 24'h0000F0; idle(4);
        chk({47'd0, irq_out}, '0, "R9 upper lines no irq");
        rd_chk(8'd3, 8'hF0, "R9 upper line level readable");

        // R10 reserved and out-of-window offsets
        wr(8'd6, 8'hAA);
        rd_chk(8'd6, 8'h00, "R10 offset 6 reads zero");
        wr(8'd11, 8'h55);
        rd_chk(8'd11, 8'h00, "R10 offset 11 reads zero");
        chk(pad_oe, {8'hC3, 32'd0, 8'h5A}, "R10 writes changed no enables");
        rd_chk(8'd7, 8'h80, "R10 page unchanged");

        // pseudo-random traffic against the model
        lf = 32'h1ACE_B00C;
        for (int n = 0; n < 3000; n++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            cyc();
            bus_wr    = lf[0] & lf[1];
            bus_rd    = lf[2];
            bus_addr  = 8'(lf[7:4] % 12);
            bus_wdata = lf[15:8];
            if (lf[3]) pad_in[lf[23:20] + 16*(lf[25:24] % 3)] ^= 1'b1;
        end
        cyc();
        bus_wr = 1'b0; bus_rd = 1'b0;
        idle(2);

        // R1 reset mid-run
        rst_n = 1'b0;
        #1;
        chk(pad_oe, '0, "R1 pad_oe on reset");
        chk({47'd0, irq_out}, '0, "R1 irq on reset");
        idle(2);
        finish_run();
    end
endmodule